// File: doc/BRIEF.md
# Parallel Flash Programming Front End

This block lets an external programmer reach an on-chip flash array through reassigned port pins while the processor core is held in reset. The programmer enters programming mode by pulling the program-enable pin low while the core reset is high. It then arms the block with an ID read. After that it issues commands on the falling edge of a command strobe. A five-bit code selects each command. The address is gathered from three separate port fields. The data port is driven for ID reads and verifies, and a ready pin reports busy while a self-timed erase or program runs.

The flash array is modelled as a small behavioural byte memory. Each operation class has its own fixed busy time. All pins are sampled on the block clock, so pin edges are detected one clock edge at a time.

Top module: `flash_pgm_frontend`

## Requirements
- R1: `in_mode` rises after a clock edge that samples `prog_en_n` low, where the previous edge sampled it high and `cpu_rst` is high. Holding `prog_en_n` low from reset release with no high-to-low transition never enters the mode.
- R2: At the next edge after `cpu_rst` goes low or `prog_en_n` goes high, both `in_mode` and `armed` clear. After the block re-enters the mode, non-ID commands are ignored until a new ID read is done.
- R3: The ID read (code 5'h00) is accepted whether or not the block is armed, and it sets `armed`. Every other command received while unarmed is ignored: `ready` stays 1 and memory is unchanged.
- R4: The command code is `cmd_sel` = {ea_n, p3.7, p3.6, p2.7, p2.6}. The codes are:
  - 00 ID read
  - 01 chip erase
  - 02 block erase
  - 03 sector erase
  - 04 byte program
  - 05 burst program
  - 06 verify
  - 07/08/09 security bits 0/1/2
  - 0A/0B reset-vector bits 0/1

  The codes 0C to 1F are ignored.
- R5: The address is assembled as A15 = `addr_top[1]`, A14 = `addr_top[0]`, A13..A8 = `addr_mid` and A7..A0 = `addr_lo`. The memory index is {A15, A6..A0}.
- R6: An accepted ID read or verify puts its byte on `data_out`. `data_oe` is high from the edge that accepts the read until `strobe_n` returns high. An ID read returns `ID_MFR` when `addr_lo` = 0, `ID_DEV` when `addr_lo` = 1, and otherwise the lock status {3'b0, rv[1:0], sec[2:0]}. A verify returns the stored byte.
- R7: Byte program and burst program write `data_in` to the addressed byte, with busy lasting `T_PROG` cycles.
- R8: Sector erase sets every byte of the 16-byte sector that holds the index to 8'hFF, with busy lasting `T_SECT` cycles.
- R9: Block erase with A[15:12] = 4'hF erases the indices whose top bit is 1. With A15 = 0 it erases the indices whose top bit is 0. Both take `T_BULK` cycles. Any other A[15:12] is ignored.
- R10: Chip erase sets every byte to 8'hFF and clears all lock bits, with busy lasting `T_BULK` cycles.
- R11: Each security-bit or reset-vector-bit command sets its lock bit, with busy lasting `T_PROG` cycles.
- R12: `ready` is low for exactly the busy duration, counted in clock cycles after the accepting edge. Command strobes that arrive while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Block reset, active low |
| cpu_rst | input | 1 | Core reset pin, high holds the core in reset |
| prog_en_n | input | 1 | Program-enable pin, active low |
| strobe_n | input | 1 | Command strobe, command taken on its falling edge |
| cmd_sel | input | 5 | Command code pins |
| addr_lo | input | 8 | Address A7..A0 |
| addr_mid | input | 6 | Address A13..A8 |
| addr_top | input | 2 | Address A15 (bit 1) and A14 (bit 0) |
| data_in | input | 8 | Program data |
| data_out | output | 8 | Read data |
| data_oe | output | 1 | Data port drive enable |
| ready | output | 1 | 1 = ready, 0 = busy |
| in_mode | output | 1 | Programming mode active |
| armed | output | 1 | ID read has armed the block |

## Verification
Assertions check a set of invariants on every cycle:
- mode entry follows a sampled high-to-low transition of program enable while core reset is high;
- leaving the mode clears the arm flag;
- an unarmed block never goes busy;
- the data drive enable appears only inside the mode;
- the busy counter only falls and stays within bounds.

Memory contents can only be shown by the bench's directed scenarios, which read them back through verify and ID reads. These include sector and block erase boundaries, the rejected block selector, strobes ignored while busy, lock bit status, and the exact busy length of each operation class.

// File: rtl/flash_pgm_frontend.sv
module flash_pgm_frontend #(
  parameter int MEM_AW = 8,
  parameter int SECT_AW = 4,
  parameter int T_PROG = 6,
  parameter int T_SECT = 12,
  parameter int T_BULK = 24,
  parameter logic [7:0] ID_MFR = 8'hA5,
  parameter logic [7:0] ID_DEV = 8'h3C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_rst,
  input  logic       prog_en_n,
  input  logic       strobe_n,
  input  logic [4:0] cmd_sel,
  input  logic [7:0] addr_lo,
  input  logic [5:0] addr_mid,
  input  logic [1:0] addr_top,
  input  logic [7:0] data_in,
  output logic [7:0] data_out,
  output logic       data_oe,
  output logic       ready,
  output logic       in_mode,
  output logic       armed
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int CW = $clog2(T_BULK + 1);

  logic [7:0] mem [DEPTH];
  logic [CW-1:0] busy_cnt;
  logic pe_q, strobe_q, rd_valid;
  logic [2:0] sec;
  logic [1:0] rv;

  wire [15:0] addr = {addr_top, addr_mid, addr_lo};
  wire [MEM_AW-1:0] idx = {addr[15], addr[MEM_AW-2:0]};
  wire unused_hi = ^addr[14:MEM_AW-1];
  wire mode_ok = cpu_rst & ~prog_en_n;
  wire fall = strobe_q & ~strobe_n;
  wire accept = in_mode & mode_ok & fall & ready;
  wire blk_hi = addr[15:12] == 4'hF;
  wire blk_lo = ~addr[15];

  assign ready = busy_cnt == '0;
  assign data_oe = rd_valid & ~strobe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe_q <= 1'b0;
      strobe_q <= 1'b0;
      in_mode <= 1'b0;
      armed <= 1'b0;
      rd_valid <= 1'b0;
      data_out <= '0;
      busy_cnt <= '0;
      sec <= '0;
      rv <= '0;
      for (int j = 0; j < DEPTH; j++) mem[j] <= 8'hFF;
    end else begin
      pe_q <= prog_en_n;
      strobe_q <= strobe_n;
      if (!mode_ok) in_mode <= 1'b0;
      else if (pe_q) in_mode <= 1'b1;
      if (!mode_ok) armed <= 1'b0;
      if (strobe_n || !mode_ok) rd_valid <= 1'b0;
      if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;

      if (accept && cmd_sel == 5'h00) begin
        armed <= 1'b1;
        rd_valid <= 1'b1;
        case (addr_lo)
          8'h00:   data_out <= ID_MFR;
          8'h01:   data_out <= ID_DEV;
          default: data_out <= {3'b000, rv, sec};
        endcase
      end else if (accept && armed) begin
        case (cmd_sel)
          5'h01: begin
            for (int j = 0; j < DEPTH; j++) mem[j] <= 8'hFF;
            sec <= '0;
            rv <= '0;
            busy_cnt <= CW'(T_BULK);
          end
          5'h02: if (blk_hi || blk_lo) begin
            for (int j = 0; j < DEPTH; j++)
              if (j[MEM_AW-1] == blk_hi) mem[j] <= 8'hFF;
            busy_cnt <= CW'(T_BULK);
          end
          5'h03: begin
            for (int j = 0; j < DEPTH; j++)
              if ((j >> SECT_AW) == (int'(idx) >> SECT_AW)) mem[j] <= 8'hFF;
            busy_cnt <= CW'(T_SECT);
          end
          5'h04, 5'h05: begin
            mem[idx] <= data_in;
            busy_cnt <= CW'(T_PROG);
          end
          5'h06: begin
            data_out <= mem[idx];
            rd_valid <= 1'b1;
          end
          5'h07, 5'h08, 5'h09: begin
            sec[cmd_sel[1:0] - 2'd3] <= 1'b1;
            busy_cnt <= CW'(T_PROG);
          end
          5'h0A, 5'h0B: begin
            rv[cmd_sel[0]] <= 1'b1;
            busy_cnt <= CW'(T_PROG);
          end
          default: ;
        endcase
      end
    end
  end

  p_enter_cond_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_mode) |-> $past(cpu_rst) && !$past(prog_en_n));
  p_exit_disarm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rst || prog_en_n) |=> !armed && !in_mode);
  p_unarmed_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && ready) |=> ready);
  p_oe_in_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> in_mode);
  p_busy_falls_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ready || busy_cnt < $past(busy_cnt));
  p_busy_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= CW'(T_BULK));
endmodule

// File: tb/tb_flash_pgm_frontend.sv
module tb_flash_pgm_frontend;
  localparam int TP = 6, TS = 12, TB = 24;
  logic clk = 0, rst_n = 0, cpu_rst = 1, prog_en_n = 0, strobe_n = 1;
  logic [4:0] cmd_sel = 0;
  logic [15:0] a = 0;
  logic [7:0] data_in = 0, data_out;
  logic data_oe, ready, in_mode, armed;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_pgm_frontend #(.T_PROG(TP), .T_SECT(TS), .T_BULK(TB)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_rst(cpu_rst), .prog_en_n(prog_en_n),
    .strobe_n(strobe_n), .cmd_sel(cmd_sel), .addr_lo(a[7:0]),
    .addr_mid(a[13:8]), .addr_top(a[15:14]), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .ready(ready),
    .in_mode(in_mode), .armed(armed));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int rd, oe, busy;
  task automatic op(logic [4:0] c, logic [15:0] ad, logic [7:0] d);
    @(negedge clk);
    cmd_sel = c; a = ad; data_in = d; strobe_n = 0;
    @(negedge clk);
    rd = data_out; oe = data_oe;
    strobe_n = 1;
    busy = 0;
    while (!ready) begin busy++; @(negedge clk); end
  endtask

  task automatic verify(string req, logic [15:0] ad, logic [7:0] exp);
    op(5'h06, ad, 0);
    chk(req, rd, exp);
  endtask

  task automatic t_entry();
    repeat (3) @(negedge clk);
    chk("R1 no entry without edge", in_mode, 0);
    prog_en_n = 1; @(negedge clk);
    prog_en_n = 0; @(negedge clk);
    chk("R1 entry on falling edge", in_mode, 1);
  endtask

  task automatic t_unarmed();
    op(5'h04, 16'h0005, 8'h12);
    chk("R3 unarmed program ignored busy", busy, 0);
    op(5'h00, 16'h0000, 0);
    chk("R3 id read arms", armed, 1);
    chk("R6 id mfr", rd, 8'hA5);
    chk("R6 oe during read", oe, 1);
    @(negedge clk);
    chk("R6 oe drops after strobe", data_oe, 0);
    op(5'h00, 16'h0001, 0);
    chk("R6 id dev", rd, 8'h3C);
    verify("R3 unarmed write left memory", 16'h0005, 8'hFF);
  endtask

  task automatic t_program();
    op(5'h04, 16'h0005, 8'h12);
    chk("R12 program busy length", busy, TP);
    verify("R7 byte program", 16'h0005, 8'h12);
    op(5'h05, 16'h8003, 8'h77);
    chk("R7 burst busy", busy, TP);
    verify("R5 A15 upper half", 16'h8003, 8'h77);
    verify("R5 lower half distinct", 16'h0003, 8'hFF);
  endtask

  task automatic t_busy_ignore();
    @(negedge clk);
    cmd_sel = 5'h04; a = 16'h0010; data_in = 8'h55; strobe_n = 0;
    @(negedge clk); strobe_n = 1;
    @(negedge clk);
    cmd_sel = 5'h04; a = 16'h0011; data_in = 8'h66; strobe_n = 0;
    @(negedge clk); strobe_n = 1;
    while (!ready) @(negedge clk);
    verify("R12 first write done", 16'h0010, 8'h55);
    verify("R12 strobe while busy ignored", 16'h0011, 8'hFF);
  endtask

  task automatic t_invalid();
    op(5'h1F, 16'h0012, 8'h00);
    chk("R4 invalid code no busy", busy, 0);
    op(5'h0C, 16'h0012, 8'h00);
    chk("R4 code 0C no busy", busy, 0);
    verify("R4 invalid no write", 16'h0012, 8'hFF);
  endtask

  task automatic t_sector();
    op(5'h04, 16'h0020, 8'h01);
    op(5'h04, 16'h002F, 8'h02);
    op(5'h04, 16'h0030, 8'h03);
    op(5'h03, 16'h0025, 0);
    chk("R8 sector busy", busy, TS);
    verify("R8 sector start erased", 16'h0020, 8'hFF);
    verify("R8 sector end erased", 16'h002F, 8'hFF);
    verify("R8 next sector kept", 16'h0030, 8'h03);
  endtask

  task automatic t_block();
    op(5'h04, 16'h8040, 8'h11);
    op(5'h04, 16'h0040, 8'h22);
    op(5'h02, 16'hA000, 0);
    chk("R9 bad selector no busy", busy, 0);
    verify("R9 bad selector kept", 16'h8040, 8'h11);
    op(5'h02, 16'hF000, 0);
    chk("R9 block busy", busy, TB);
    verify("R9 upper erased", 16'h8040, 8'hFF);
    verify("R9 lower kept", 16'h0040, 8'h22);
    op(5'h02, 16'h3000, 0);
    verify("R9 lower erased", 16'h0040, 8'hFF);
  endtask

  task automatic t_lock();
    op(5'h07, 0, 0);
    chk("R11 sec busy", busy, TP);
    op(5'h0B, 0, 0);
    op(5'h00, 16'h0002, 0);
    chk("R11 lock status", rd, 8'h11);
  endtask

  task automatic t_chip();
    op(5'h04, 16'h0001, 8'h09);
    op(5'h01, 0, 0);
    chk("R10 chip busy", busy, TB);
    verify("R10 chip erased", 16'h0001, 8'hFF);
    verify("R10 program count", 16'h0005, 8'hFF);
    op(5'h00, 16'h0002, 0);
    chk("R10 lock cleared", rd, 0);
  endtask

  task automatic t_exit();
    @(negedge clk); prog_en_n = 1;
    @(negedge clk);
    chk("R2 exit mode", in_mode, 0);
    chk("R2 exit disarm", armed, 0);
    prog_en_n = 0; @(negedge clk);
    chk("R2 re-entry", in_mode, 1);
    op(5'h04, 16'h0007, 8'h44);
    chk("R2 unarmed after re-entry", busy, 0);
    op(5'h00, 0, 0);
    verify("R2 no write before arm", 16'h0007, 8'hFF);
    @(negedge clk); cpu_rst = 0;
    @(negedge clk);
    chk("R2 core reset low exits", in_mode, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("reset in_mode", in_mode, 0);
    chk("reset ready", ready, 1);
    chk("reset data_oe", data_oe, 0);
    rst_n = 1;
    t_entry();
    t_unarmed();
    t_program();
    t_busy_ignore();
    t_invalid();
    t_sector();
    t_block();
    t_lock();
    t_chip();
    t_exit();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule